// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, A and B, and can pass data either way. Each direction owns a storage register that samples its source bus on the rising edge of a clock dedicated to that direction. On the driven side a per-direction select picks either the live value from the opposite bus or the value held in the register. An active-low output enable and a direction input together choose which bus, if either, is driven.

Each bus side is modelled as three separate signals: an input word, an output word and an output enable. A pad ring or a tristate wrapper at the chip edge combines them. The live path is purely combinational. The registers clear to zero under an asynchronous active-low reset. In each clock domain the release of that reset is synchronised, so that domain starts capturing only after the release has passed its synchroniser.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: The A-side register samples the effective A value on each rising edge of `clk_ab` once reset release has passed its synchroniser. Sampling happens for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R2: The B-side register samples the effective B value on each rising edge of `clk_ba` once reset release has passed its synchroniser. Sampling happens for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`.
- R3: While `oe_n` = 1, `a_oe` = 0, `b_oe` = 0, `a_out` = 0 and `b_out` = 0. Both registers keep sampling during this time.
- R4: While `oe_n` = 0, `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R5: While A is driven, `a_out` equals `b_in` in the same cycle when `sel_ba` = 0, and equals the B-side register when `sel_ba` = 1.
- R6: While B is driven, `b_out` equals `a_in` in the same cycle when `sel_ab` = 0, and equals the A-side register when `sel_ab` = 1.
- R7: The effective value of a bus is its output word while that bus is driven, and its input word otherwise. A register whose source bus is driven therefore stores the value being driven out. No path inverts data.
- R8: An active-low `rst_n` clears both registers to 0 at once. After `rst_n` rises, the first two rising edges of a register's clock do not change it, and sampling begins on the third.
- R9: `a_oe` and `b_oe` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Sampling clock of the A-side register |
| clk_ba | input | 1 | Sampling clock of the B-side register |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable; high isolates both buses |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
A wrong stored value stays hidden until the opposite side is driven with its stored-path select set. It then shows as a bad output word in that same cycle, which may be many clock edges after the faulty sample was taken. For this reason the stimulus reads each register back through its stored path soon after each capture, and also after captures made during isolation and while the source bus was driven. Faults in the enable decode show at once on `a_oe` and `b_oe`, because the bench compares those against the expected values on every step.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_t;

  localparam int unsigned LANE_AB = 0;
  localparam int unsigned LANE_BA = 1;
  localparam int unsigned N_LANES = 2;

  function automatic drive_t decode_drive(input logic oe_n, input logic dir);
    drive_t d;
    d = DRV_NONE;
    if (!oe_n) begin
      d = dir ? DRV_B : DRV_A;
    end
    return d;
  endfunction

endpackage

// File: rtl/bxr_rst_sync.sv
module bxr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign run = chain_q[STAGES-1];

endmodule

// File: rtl/bxr_store_reg.sv
module bxr_store_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_next;
  logic             cap_en;

  assign cap_en = run;

  always_comb begin
    q_next = q;
    if (cap_en) begin
      q_next = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_next;
    end
  end

  AST_HOLD_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> q == $past(q)); // R8

endmodule

// File: rtl/bxr_route.sv
module bxr_route
  import bxr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] q_ab,
  input  logic [WIDTH-1:0] q_ba,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff
);

  drive_t           drv;
  logic [WIDTH-1:0] to_a;
  logic [WIDTH-1:0] to_b;

  always_comb begin
    drv  = decode_drive(oe_n, dir);
    a_oe = (drv == DRV_A);
    b_oe = (drv == DRV_B);
  end

  always_comb begin
    to_a = sel_ba ? q_ba : b_in;
    to_b = sel_ab ? q_ab : a_in;
  end

  always_comb begin
    a_out = a_oe ? to_a : '0;
    b_out = b_oe ? to_b : '0;
    a_eff = a_oe ? to_a : a_in;
    b_eff = b_oe ? to_b : b_in;
  end

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import bxr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic [N_LANES-1:0] lane_clk;
  logic [N_LANES-1:0] lane_run;
  logic [WIDTH-1:0]   lane_d [N_LANES];
  logic [WIDTH-1:0]   lane_q [N_LANES];
  logic [WIDTH-1:0]   a_eff;
  logic [WIDTH-1:0]   b_eff;

  assign lane_clk[LANE_AB] = clk_ab;
  assign lane_clk[LANE_BA] = clk_ba;
  assign lane_d[LANE_AB]   = a_eff;
  assign lane_d[LANE_BA]   = b_eff;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    bxr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (lane_clk[g]),
      .rst_n (rst_n),
      .run   (lane_run[g])
    );

    bxr_store_reg #(.WIDTH(WIDTH)) u_reg (
      .clk   (lane_clk[g]),
      .rst_n (rst_n),
      .run   (lane_run[g]),
      .d     (lane_d[g]),
      .q     (lane_q[g])
    );
  end

  bxr_route #(.WIDTH(WIDTH)) u_route (
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .q_ab   (lane_q[LANE_AB]),
    .q_ba   (lane_q[LANE_BA]),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .a_eff  (a_eff),
    .b_eff  (b_eff)
  );

  AST_ONE_DRIVER: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_oe && b_oe)); // R9

  AST_ISOLATED: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R3

  AST_LIVE_TO_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && !sel_ab) |-> b_out == a_in); // R6

  AST_STORED_AB: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (lane_run[LANE_AB] && !a_oe) |=> (!(b_oe && sel_ab) || b_out == $past(a_in))); // R1

  AST_STORED_BA: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (lane_run[LANE_BA] && !b_oe) |=> (!(a_oe && sel_ba) || a_out == $past(b_in))); // R2

endmodule

// File: tb/bidir_reg_xcvr_test.sv
module bidir_reg_xcvr_test;

  localparam int W = 8;

  typedef struct {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         gate_ab = 1'b0;
  logic         gate_ba = 1'b0;
  logic         clk_ab;
  logic         clk_ba;
  logic         rst_n = 1'b0;
  logic         oe_n = 1'b1;
  logic         dir = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out;
  logic [W-1:0] b_out;
  logic         a_oe;
  logic         b_oe;

  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;
  item_t        sb_q[$];

  logic [W-1:0] m_ab = '0;
  logic [W-1:0] m_ba = '0;
  int           cnt_ab = 0;
  int           cnt_ba = 0;

  always #5 clk = ~clk;
  assign clk_ab = clk & gate_ab;
  assign clk_ba = clk & gate_ba;

  bidir_reg_xcvr #(.WIDTH(W)) uut (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst_n  (rst_n),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
  );

  task automatic step(input logic t_oe_n, input logic t_dir, input logic t_sab,
                      input logic t_sba, input logic [W-1:0] t_a, input logic [W-1:0] t_b,
                      input logic g_ab, input logic g_ba, input string req);
    item_t        it;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
    @(negedge clk);
    oe_n = t_oe_n; dir = t_dir; sel_ab = t_sab; sel_ba = t_sba;
    a_in = t_a; b_in = t_b; gate_ab = g_ab; gate_ba = g_ba;
    it.a_oe  = !t_oe_n && !t_dir;
    it.b_oe  = !t_oe_n && t_dir;
    it.a_out = it.a_oe ? (t_sba ? m_ba : t_b) : '0;
    it.b_out = it.b_oe ? (t_sab ? m_ab : t_a) : '0;
    it.req   = req;
    sb_q.push_back(it);
    ea = it.a_oe ? it.a_out : t_a;
    eb = it.b_oe ? it.b_out : t_b;
    if (rst_n && g_ab) begin
      if (cnt_ab >= 2) m_ab = ea;
      if (cnt_ab < 2) cnt_ab++;
    end
    if (rst_n && g_ba) begin
      if (cnt_ba >= 2) m_ba = eb;
      if (cnt_ba < 2) cnt_ba++;
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (a_oe !== it.a_oe || b_oe !== it.b_oe || a_out !== it.a_out || b_out !== it.b_out) begin
          fails++;
          $display("FAIL %s: got a_oe=%b b_oe=%b a_out=%h b_out=%h, expected a_oe=%b b_oe=%b a_out=%h b_out=%h",
                   it.req, a_oe, b_oe, a_out, b_out, it.a_oe, it.b_oe, it.a_out, it.b_out);
        end
        checks++;
        if (a_oe === 1'b1 && b_oe === 1'b1) begin
          fails++;
          $display("FAIL R9: got a_oe=1 b_oe=1, expected at most one set");
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    // R8: reset state seen through stored paths
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, "R8");
    @(negedge clk);
    rst_n = 1'b1;
    // R8: two edges after release do not capture
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hA5, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hA5, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hA5, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hA5, 1'b0, 1'b0, "R8");
    // R3: isolation with capture on both clocks
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3, 1'b1, 1'b1, "R3");
    // R1/R6: stored A onto B; R2/R5: stored B onto A
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
    // R6 live A onto B, R5 live B onto A
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h96, 8'h21, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h96, 8'h21, 1'b0, 1'b0, "R5");
    // R7: A is driven with live B; A register stores the driven value
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h77, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R7");
    // R7: B driven from stored A; B register stores it
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hE0, 8'h0E, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R7");
    // R4: sweep of every enable/direction/select setting with varied data
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 16; c++) begin
        step(c[3], c[2], c[1], c[0], 8'((r * 16 + c) * 37 + 5), 8'((r * 16 + c) * 91 + 13),
             ((c + r) % 3) == 0, ((c + r) % 2) == 1, "R4");
      end
    end
    // R8: asynchronous reset clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    m_ab = '0; m_ba = '0; cnt_ab = 0; cnt_ba = 0;
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55, 1'b0, 1'b0, "R8");
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule